// File: doc/BRIEF.md
# Strobe-Driven ROM Address Sequencer

This block is the host-facing control logic of a byte-wide read-only store that is reached through a command interface rather than a parallel address bus. A host drives an 8-bit data bus, an active-low chip select, active-low write and read strobes, and a 3-bit register select. The host sets the 22-bit read address over one to three byte writes. An internal byte pointer picks the address byte that each write fills, starting with the least significant byte. Each read strobe returns the byte stored at the current address, and the address then advances by one. A host can therefore stream a block of data after loading the address only once.

The pointer returns to the low byte when the chip is deselected or when a ROM read starts. Accesses to the expansion register space (select bit 2 high) leave the pointer where it is. An interrupt routine can therefore use those registers in the middle of an address load, and the load continues from where it stopped. The strobes are asynchronous to the system clock. They pass through a synchronizer, and all state changes on the sampled strobe edges. The array itself is a registered lookup of the address counter.

Top module: `strobe_rom_seq`

## Requirements
- R1: After synchronous reset the address counter is 0, the byte pointer selects the low address byte, and the data-bus drive enable `dout_oe` is 0.
- R2: While select bit 2 is 0, select bits 1 and 0 have no effect: a write with select 3'b011 loads the address exactly as a write with select 3'b000 does.
- R3: Address bytes load least-significant first: the first write after a pointer reset sets A7..A0, the second A15..A8, the third A21..A16. Only bits 5..0 of the third byte are kept.
- R4: Once the pointer has reached the top byte it stays there, so a fourth and any later write replace A21..A16 again.
- R5: Raising the chip select (deselect) returns the pointer to the low byte, and the next address write sets A7..A0.
- R6: A ROM read (read strobe low with select bit 2 at 0) returns the pointer to the low byte.
- R7: Reads and writes with select bit 2 at 1 neither change the address counter nor move or reset the pointer, and `dout_oe` stays 0 during them.
- R8: Each ROM read drives the byte for the current address A, which is (A[7:0] + 3*A[15:8] + 5*A[21:16] + 0x5A) mod 256. The address counter then increments by one when the read strobe rises, and it wraps from 0x3FFFFF to 0x000000.
- R9: While the chip select is high, strobes have no effect: the address does not change and `dout_oe` stays 0. `dout_oe` is 1 only during a ROM read with the chip selected.
- R10: A single address write after a pointer reset replaces only A7..A0 and leaves A21..A8 unchanged (a page reload).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state is updated on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| we_n | input | 1 | Write strobe, active low; data is latched on its rising edge |
| oe_n | input | 1 | Read strobe, active low; the address advances on its rising edge |
| rsel | input | 3 | Register select; bit 2 low addresses the ROM and the address counter |
| din | input | 8 | Host data bus, inbound |
| dout | output | 8 | Host data bus, outbound ROM byte |
| dout_oe | output | 1 | Drive enable for `dout`; 0 means the bus is released (high impedance) |

## Verification
A wrong pointer position shows up only at the next ROM read. The byte returned then comes from an address in which the written byte sits in the wrong field or has replaced the wrong field. The pattern weights the three address bytes differently, so a misplaced byte changes the data returned. A wrong increment or wrap shows up one read later as the data for the wrong address. A drive enable raised at the wrong time shows up a few clocks after the strobe, once the strobe has passed the synchronizer. Every scenario therefore ends in a ROM read, or in a check of `dout_oe` while the strobe in question is still held.

// File: rtl/rom_seq_pkg.sv
package rom_seq_pkg;
  localparam int unsigned SEQ_DATA_W      = 8;
  localparam int unsigned SEQ_ADDR_W      = 22;
  localparam int unsigned SEQ_SYNC_STAGES = 2;

  // Events decoded from the synchronized host strobes.
  typedef struct packed {
    logic cs_act;   // chip selected
    logic we_fall;  // write strobe went low
    logic we_rise;  // write strobe went high
    logic oe_low;   // read strobe is active
    logic oe_rise;  // read strobe went high
  } strobe_ev_t;
endpackage

// File: rtl/seq_sync.sv
module seq_sync #(
  parameter int unsigned WIDTH = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < int'(STAGES); i++) chain[i] <= RST_VAL;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < int'(STAGES); i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/strobe_edges.sv
module strobe_edges
  import rom_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] strb_s,  // {cs_n, we_n, oe_n} after synchronization
  output strobe_ev_t ev
);
  logic cs_s, we_s, oe_s;
  logic we_prev, oe_prev;

  assign {cs_s, we_s, oe_s} = strb_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      we_prev <= 1'b1;
      oe_prev <= 1'b1;
    end else begin
      we_prev <= we_s;
      oe_prev <= oe_s;
    end
  end

  always_comb begin
    ev.cs_act  = ~cs_s;
    ev.we_fall = we_prev & ~we_s;
    ev.we_rise = ~we_prev & we_s;
    ev.oe_low  = ~oe_s;
    ev.oe_rise = ~oe_prev & oe_s;
  end
endmodule

// File: rtl/addr_loader.sv
module addr_loader
  import rom_seq_pkg::*;
#(
  parameter int unsigned DATA_W = SEQ_DATA_W,
  parameter int unsigned ADDR_W = SEQ_ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_ev_t        ev,
  input  logic              sel_hi,   // select bit 2, synchronized
  input  logic [DATA_W-1:0] din_s,
  output logic [ADDR_W-1:0] addr
);
  localparam int unsigned NLAT = (ADDR_W + DATA_W - 1) / DATA_W;
  localparam int unsigned PW   = (NLAT > 1) ? $clog2(NLAT) : 1;
  localparam logic [PW-1:0] LAST = PW'(NLAT - 1);

  logic [PW-1:0] ptr;   // next address byte to fill
  logic [PW-1:0] wsel;  // byte chosen at the falling write edge
  logic rom_sel, ptr_hold;

  assign rom_sel  = ev.cs_act & ~sel_hi;
  assign ptr_hold = ~ev.cs_act | (ev.oe_low & ~sel_hi);

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr  <= '0;
      wsel <= '0;
      addr <= '0;
    end else begin
      if (ptr_hold)
        ptr <= '0;
      else if (rom_sel && ev.we_fall && ptr != LAST)
        ptr <= ptr + PW'(1);

      if (rom_sel && ev.we_fall)
        wsel <= ptr;

      if (rom_sel && ev.we_rise) begin
        for (int b = 0; b < int'(ADDR_W); b++)
          if ((b / int'(DATA_W)) == int'(wsel))
            addr[b] <= din_s[b % int'(DATA_W)];
      end else if (rom_sel && ev.oe_rise) begin
        addr <= addr + ADDR_W'(1);
      end
    end
  end

  // Pointer never passes the top byte.
  assert_ptr_saturates_R4: assert property (@(posedge clk) disable iff (rst)
    ptr <= LAST);

  assert_deselect_clears_ptr_R5: assert property (@(posedge clk) disable iff (rst)
    !ev.cs_act |=> ptr == '0);

  assert_rom_read_clears_ptr_R6: assert property (@(posedge clk) disable iff (rst)
    (ev.cs_act && ev.oe_low && !sel_hi) |=> ptr == '0);

  assert_expansion_keeps_ptr_R7: assert property (@(posedge clk) disable iff (rst)
    (ev.cs_act && sel_hi) |=> ($stable(ptr) && $stable(addr)));

  assert_read_advances_addr_R8: assert property (@(posedge clk) disable iff (rst)
    (rom_sel && ev.oe_rise && !ev.we_rise) |=> addr == $past(addr) + ADDR_W'(1));

  assert_deselect_freezes_addr_R9: assert property (@(posedge clk) disable iff (rst)
    !ev.cs_act |=> $stable(addr));
endmodule

// File: rtl/rom_lookup.sv
module rom_lookup #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 22,
  parameter logic [DATA_W-1:0] SEED = 8'h5A,
  parameter int unsigned MEM_LIMIT = 10
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] q
);
  localparam int unsigned NLAT = (ADDR_W + DATA_W - 1) / DATA_W;

  // Weighted sum of the address bytes, weights 1, 3, 5, ...
  function automatic logic [DATA_W-1:0] pattern(input logic [ADDR_W-1:0] a);
    logic [NLAT*DATA_W-1:0] ext;
    logic [DATA_W-1:0] acc;
    ext = '0;
    ext[ADDR_W-1:0] = a;
    acc = SEED;
    for (int k = 0; k < int'(NLAT); k++)
      acc = acc + DATA_W'(ext[k*DATA_W +: DATA_W] * (2*k + 1));
    return acc;
  endfunction

  generate
    if (ADDR_W <= MEM_LIMIT) begin : g_mem
      logic [DATA_W-1:0] mem [2**ADDR_W];
      initial begin
        for (int i = 0; i < 2**ADDR_W; i++) mem[i] = pattern(ADDR_W'(i));
      end
      always_ff @(posedge clk) q <= mem[addr];
    end else begin : g_calc
      always_ff @(posedge clk) q <= pattern(addr);
    end
  endgenerate
endmodule

// File: rtl/strobe_rom_seq.sv
module strobe_rom_seq
  import rom_seq_pkg::*;
#(
  parameter int unsigned DATA_W = SEQ_DATA_W,
  parameter int unsigned ADDR_W = SEQ_ADDR_W,
  parameter int unsigned SYNC_STAGES = SEQ_SYNC_STAGES,
  parameter logic [DATA_W-1:0] SEED = 8'h5A
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [2:0]        rsel,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_oe
);
  logic [2:0]        strb_s;
  logic [DATA_W:0]   bus_s;
  logic              sel_hi;
  logic [DATA_W-1:0] din_s;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] rom_q;
  logic              read_act;
  strobe_ev_t        ev;
  logic              unused_sel_lo;

  assign unused_sel_lo = ^rsel[1:0];  // low select bits do not address anything here

  seq_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_strb_sync (
    .clk(clk), .rst(rst), .d({cs_n, we_n, oe_n}), .q(strb_s));

  seq_sync #(.WIDTH(DATA_W + 1), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_bus_sync (
    .clk(clk), .rst(rst), .d({rsel[2], din}), .q(bus_s));

  assign sel_hi = bus_s[DATA_W];
  assign din_s  = bus_s[DATA_W-1:0];

  strobe_edges u_edges (.clk(clk), .rst(rst), .strb_s(strb_s), .ev(ev));

  addr_loader #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_loader (
    .clk(clk), .rst(rst), .ev(ev), .sel_hi(sel_hi), .din_s(din_s), .addr(addr));

  rom_lookup #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SEED(SEED)) u_rom (
    .clk(clk), .addr(addr), .q(rom_q));

  assign read_act = ev.cs_act & ev.oe_low & ~sel_hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_oe <= 1'b0;
      dout    <= '0;
    end else begin
      dout_oe <= read_act;
      if (read_act) dout <= rom_q;
    end
  end

  // Bus released one cycle after a deselect is seen.
  assert_bus_released_on_deselect_R9: assert property (@(posedge clk) disable iff (rst)
    !ev.cs_act |=> !dout_oe);

  // Expansion-space select never drives the bus.
  assert_bus_released_on_expansion_R7: assert property (@(posedge clk) disable iff (rst)
    sel_hi |=> !dout_oe);
endmodule

// File: tb/tb_strobe_rom_seq.sv
module tb_strobe_rom_seq;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [2:0] rsel = 3'b000;
  logic [7:0] din = 8'h00;
  logic [7:0] dout;
  logic       dout_oe;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [21:0] m_addr = '0;
  int          m_ptr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  strobe_rom_seq dut (.clk(clk), .rst(rst), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
                      .rsel(rsel), .din(din), .dout(dout), .dout_oe(dout_oe));

  function automatic logic [7:0] pat(input logic [21:0] a);
    return 8'(a[7:0] + 3 * a[15:8] + 5 * a[21:16] + 8'h5A);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Write one byte; model follows R2, R3, R4, R7.
  task automatic host_write(input logic [2:0] sel, input logic [7:0] data);
    rsel = sel; din = data;
    wait_n(3); we_n = 1'b0;
    wait_n(4); we_n = 1'b1;
    wait_n(4);
    if (!sel[2] && !cs_n) begin
      for (int b = 0; b < 22; b++)
        if (b / 8 == m_ptr) m_addr[b] = data[b % 8];
      if (m_ptr < 2) m_ptr++;
    end
  endtask

  // Read strobe; ROM reads checked against R8, expansion reads against R7.
  task automatic host_read(input logic [2:0] sel, input string req);
    rsel = sel;
    wait_n(3); oe_n = 1'b0;
    wait_n(5);
    if (!sel[2]) begin
      chk({req, " oe"}, 32'(dout_oe), 32'd1);
      chk({req, " data"}, 32'(dout), 32'(pat(m_addr)));
    end else begin
      chk({req, " oe"}, 32'(dout_oe), 32'd0);
    end
    oe_n = 1'b1;
    wait_n(5);
    if (!sel[2]) begin
      m_addr = m_addr + 22'd1;
      m_ptr = 0;
    end
  endtask

  task automatic deselect_cycle;
    cs_n = 1'b1; wait_n(5);
    cs_n = 1'b0; wait_n(5);
    m_ptr = 0;
  endtask

  task automatic t_reset;
    wait_n(2);
    chk("R1 oe after reset", 32'(dout_oe), 32'd0);
    cs_n = 1'b0; wait_n(4);
    host_read(3'b000, "R1 addr zero");
    host_read(3'b000, "R8 increment");
  endtask

  task automatic t_full_load;
    deselect_cycle();
    host_write(3'b000, 8'hC3);
    host_write(3'b000, 8'h7E);
    host_write(3'b000, 8'hFF);
    chk("R3 model top bits", 32'(m_addr), 32'h3F7EC3);
    host_read(3'b000, "R3 full load");
    host_read(3'b000, "R8 next byte");
  endtask

  task automatic t_page_reload;
    host_write(3'b000, 8'h10);
    host_read(3'b000, "R10 page reload");
  endtask

  task automatic t_saturate;
    host_write(3'b000, 8'h11);
    host_write(3'b000, 8'h22);
    host_write(3'b000, 8'h05);
    host_write(3'b000, 8'h2A);
    chk("R4 model", 32'(m_addr), 32'h2A2211);
    host_read(3'b000, "R4 saturate");
  endtask

  task automatic t_deselect_reset;
    host_write(3'b000, 8'h40);
    deselect_cycle();
    host_write(3'b000, 8'h99);
    host_read(3'b000, "R5 deselect restart");
  endtask

  task automatic t_read_reset;
    host_write(3'b000, 8'h01);
    host_read(3'b000, "R6 read between");
    host_write(3'b000, 8'h02);
    host_read(3'b000, "R6 low byte again");
  endtask

  task automatic t_expansion;
    host_write(3'b000, 8'h33);
    host_write(3'b101, 8'hEE);
    host_read(3'b100, "R7 expansion read");
    host_write(3'b111, 8'h55);
    host_write(3'b000, 8'h44);
    host_read(3'b000, "R7 resumed load");
  endtask

  task automatic t_low_sel_ignored;
    deselect_cycle();
    host_write(3'b011, 8'h77);
    host_write(3'b010, 8'h21);
    host_read(3'b001, "R2 low select bits");
  endtask

  task automatic t_deselected_ignored;
    cs_n = 1'b1; wait_n(4);
    rsel = 3'b000; din = 8'hAB;
    wait_n(3); we_n = 1'b0; wait_n(4); we_n = 1'b1; wait_n(4);
    oe_n = 1'b0; wait_n(5);
    chk("R9 oe while deselected", 32'(dout_oe), 32'd0);
    oe_n = 1'b1; wait_n(5);
    cs_n = 1'b0; wait_n(5);
    m_ptr = 0;
    host_read(3'b000, "R9 addr unchanged");
  endtask

  task automatic t_wrap;
    deselect_cycle();
    host_write(3'b000, 8'hFF);
    host_write(3'b000, 8'hFF);
    host_write(3'b000, 8'hFF);
    chk("R8 model top", 32'(m_addr), 32'h3FFFFF);
    host_read(3'b000, "R8 last address");
    chk("R8 model wrap", 32'(m_addr), 32'h0);
    host_read(3'b000, "R8 wrap to zero");
  endtask

  initial begin
    wait_n(4);
    rst = 1'b0;
    t_reset();
    t_full_load();
    t_page_reload();
    t_saturate();
    t_deselect_reset();
    t_read_reset();
    t_expansion();
    t_low_sel_ignored();
    t_deselected_ignored();
    t_wrap();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule